// File: doc/BRIEF.md
# Frame Mailbox Register Block

This block sits between a host register bus and the byte streams of an Ethernet MAC core. It holds one received frame and one frame to send. Each frame passes through a single 32-bit data register: the host pops receive words from it, or pushes transmit words into it. Receive status and transmit control each have their own register.

A received frame is written into an internal buffer byte by byte. When the last byte lands, a ready flag, the byte length and two error flags become visible. The host drains the words and then writes zero to the receive control register to release the buffer for the next frame. To send, the host pushes words and writes the length with the start bit set. Hardware streams the bytes out and clears start when the last byte is accepted. The host then acknowledges the result by writing zero.

An interrupt-enable register gates two causes onto one interrupt line. The receive cause is a level that stays high while a frame waits. The transmit cause is a one-cycle pulse per completion, and it is lost if it fires while masked.

Top module: `frame_mailbox`

## Requirements
- R1: After reset, the receive control, transmit control and interrupt-enable registers all read zero, and both `irq_o` and `tx_valid_o` are low.
- R2: Register offsets are 0 for receive control, 1 for receive data, 2 for transmit control, 3 for transmit data and 4 for interrupt enable. Once a frame of N bytes completes, receive control reads bit 31 = 1 and bits [13:0] = N. Successive reads of receive data return ceil(N/4) words. Byte i sits in word i/4 at bits [8*(i%4)+7 : 8*(i%4)], and the unused byte lanes of the last word read zero.
- R3: `rx_err_i[0]` on the end-of-frame byte sets receive control bit 30. `rx_err_i[1]` on that byte sets bit 29.
- R4: A read of receive data with no frame pending, or after all of the frame's words have been read, returns zero and does not advance the read position.
- R5: Writing zero to receive control clears that whole register and releases the buffer. A nonzero write to it has no effect.
- R6: A frame that arrives while a received frame is still pending is dropped. The pending frame's length and data are unchanged, and nothing is presented after the acknowledge.
- R7: A received frame longer than the buffer (2048 bytes by default) keeps only its first 2048 bytes. It reports length 2048 with bit 30 set.
- R8: Writing transmit control with bit 31 set and length L in [13:0] streams the L pushed bytes in order, honouring `tx_ready_i`. `tx_sof_o` marks only the first byte and `tx_eof_o` only the last. Bit 31 reads 1 until the last byte is accepted; after that the register reads bit 31 = 0 with L in [13:0].
- R9: While bit 31 of transmit control is set, pushes to transmit data and further start writes are ignored.
- R10: A `tx_err_i` pulse during sending sets transmit control bit 30 after completion. Writing zero to transmit control once it is idle clears the register.
- R11: A start with length 0 or larger than the buffer sends no bytes. It completes at once, reading bit 31 = 0, bit 30 = 1 and length 0.
- R12: The interrupt-enable register has bit 0 for receive and bit 1 for transmit. `irq_o` is high while a received frame is pending with bit 0 set. Each transmit completion raises `irq_o` for exactly one cycle if bit 1 is set at that moment; otherwise the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_sof_i | input | 1 | First byte of a receive frame |
| rx_eof_i | input | 1 | Last byte of a receive frame |
| rx_err_i | input | 2 | Error tag on the last byte: bit 0 general, bit 1 CRC |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_sof_o | output | 1 | First transmit byte |
| tx_eof_o | output | 1 | Last transmit byte |
| tx_ready_i | input | 1 | MAC accepts the transmit byte |
| tx_err_i | input | 1 | MAC reports a transmit error |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench covers frame lengths that end on every byte lane. A design that leaked stale buffer contents into the unused lanes of the last word, or that got the word count off by one, would return wrong data or a stray word where zero is expected. It also reads past the end of a frame and sends a second frame while one is pending. A design that advanced its pointer on an empty read, or overwrote a pending frame, would show up in those read-backs. Transmit runs under random backpressure with pushes and starts injected mid-send, so a design that lost a byte on a stalled handshake or accepted a push while busy would stream a corrupted frame. The zero-length and oversized starts, the 2050-byte receive and a transmit completion while masked cover the edges where a design would hang, overrun the buffer or raise a late interrupt.

// File: rtl/frame_mailbox_pkg.sv
package frame_mailbox_pkg;
  localparam logic [2:0] REG_RX_CTRL = 3'd0;
  localparam logic [2:0] REG_RX_DATA = 3'd1;
  localparam logic [2:0] REG_TX_CTRL = 3'd2;
  localparam logic [2:0] REG_TX_DATA = 3'd3;
  localparam logic [2:0] REG_IRQ_EN  = 3'd4;
  localparam int BIT_BUSY = 31;
  localparam int BIT_ERR  = 30;
  localparam int BIT_CRC  = 29;
  localparam int IRQ_RX   = 0;
  localparam int IRQ_TX   = 1;
endpackage

// File: rtl/fm_rx_buf.sv
module fm_rx_buf #(
  parameter int DEPTH_BYTES = 2048,
  parameter int LEN_W       = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_sof_i,
  input  logic             s_eof_i,
  input  logic [1:0]       s_err_i,
  input  logic             pop_i,
  input  logic             ack_i,
  output logic             ready_o,
  output logic             err_o,
  output logic             crc_o,
  output logic [LEN_W-1:0] len_o,
  output logic [31:0]      word_o
);
  localparam int WORDS = DEPTH_BYTES / 4;
  localparam int WA_W  = $clog2(WORDS);
  localparam int BA_W  = $clog2(DEPTH_BYTES) + 1;

  logic [31:0]     mem [WORDS];
  logic [BA_W-1:0] cnt_q, len_q, rd_ptr_q, wr_idx, nwords;
  logic            act_q, ovf_q, ready_q, err_q, crc_q;
  logic            start, taking, wr_en, avail, last_word;
  logic [31:0]     raw_word;

  always_comb begin
    start  = s_valid_i & s_sof_i & ~ready_q;
    taking = s_valid_i & ~ready_q & (start | act_q);
    wr_idx = start ? '0 : cnt_q;
    wr_en  = taking & (wr_idx < BA_W'(DEPTH_BYTES));
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_idx[WA_W+1:2]][8*wr_idx[1:0] +: 8] <= s_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; len_q <= '0; rd_ptr_q <= '0;
      act_q <= 1'b0; ovf_q <= 1'b0; ready_q <= 1'b0; err_q <= 1'b0; crc_q <= 1'b0;
    end else begin
      if (ack_i) begin
        ready_q <= 1'b0; err_q <= 1'b0; crc_q <= 1'b0;
        len_q <= '0; rd_ptr_q <= '0;
      end else if (pop_i && avail) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
      if (taking) begin
        cnt_q <= wr_en ? wr_idx + 1'b1 : wr_idx;
        ovf_q <= (start ? 1'b0 : ovf_q) | ~wr_en;
        act_q <= ~s_eof_i;
        if (s_eof_i) begin
          ready_q <= 1'b1;
          len_q   <= wr_en ? wr_idx + 1'b1 : wr_idx;
          err_q   <= s_err_i[0] | (start ? 1'b0 : ovf_q) | ~wr_en;
          crc_q   <= s_err_i[1];
        end
      end
    end
  end

  // read side: words past the frame read zero, and so do the unused lanes of the last word
  always_comb begin
    nwords    = BA_W'((len_q + BA_W'(3)) >> 2);
    avail     = ready_q & (rd_ptr_q < nwords);
    last_word = (rd_ptr_q == nwords - 1'b1) && (len_q[1:0] != 2'd0);
    raw_word  = mem[rd_ptr_q[WA_W-1:0]];
    word_o    = '0;
    for (int k = 0; k < 4; k++) begin
      if (avail && (!last_word || k < int'(len_q[1:0]))) word_o[8*k +: 8] = raw_word[8*k +: 8];
    end
  end

  assign ready_o = ready_q;
  assign err_o   = err_q;
  assign crc_o   = crc_q;
  assign len_o   = LEN_W'(len_q);

  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ready_o && !err_o && !crc_o);
  a_r4_empty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !avail && !ack_i |=> $stable(rd_ptr_q));
  a_r6_pending_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !ack_i |=> ready_o && $stable(len_o));
  a_r7_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (len_q <= BA_W'(DEPTH_BYTES)) && (len_q != '0));
endmodule

// File: rtl/fm_tx_buf.sv
module fm_tx_buf #(
  parameter int DEPTH_BYTES = 2048,
  parameter int LEN_W       = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [31:0]      push_data_i,
  input  logic             go_i,
  input  logic [LEN_W-1:0] go_len_i,
  input  logic             ack_i,
  input  logic             m_ready_i,
  input  logic             m_err_i,
  output logic             m_valid_o,
  output logic [7:0]       m_data_o,
  output logic             m_sof_o,
  output logic             m_eof_o,
  output logic             busy_o,
  output logic             err_o,
  output logic [LEN_W-1:0] len_o,
  output logic             done_o
);
  localparam int WORDS = DEPTH_BYTES / 4;
  localparam int WA_W  = $clog2(WORDS);
  localparam int BA_W  = $clog2(DEPTH_BYTES) + 1;

  logic [31:0]     mem [WORDS];
  logic [BA_W-1:0] wr_ptr_q, idx_q, len_q, sent_q;
  logic            busy_q, err_q, done_q, bad_len, do_push;
  logic [31:0]     cur_word;

  assign bad_len = (go_len_i == '0) || (go_len_i > LEN_W'(DEPTH_BYTES));
  assign do_push = push_i & ~busy_q & (wr_ptr_q < BA_W'(WORDS));

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q[WA_W-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0; idx_q <= '0; len_q <= '0; sent_q <= '0;
      busy_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
        if (go_i) begin
          wr_ptr_q <= '0;
          sent_q   <= '0;
          idx_q    <= '0;
          if (bad_len) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            len_q  <= go_len_i[BA_W-1:0];
          end
        end else if (ack_i) begin
          err_q <= 1'b0; sent_q <= '0; wr_ptr_q <= '0;
        end
      end else begin
        if (m_err_i) err_q <= 1'b1;
        if (m_ready_i) begin
          if (m_eof_o) begin
            busy_q <= 1'b0;
            sent_q <= len_q;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign cur_word  = mem[idx_q[WA_W+1:2]];
  assign m_valid_o = busy_q;
  assign m_data_o  = cur_word[8*idx_q[1:0] +: 8];
  assign m_sof_o   = busy_q & (idx_q == '0);
  assign m_eof_o   = busy_q & (idx_q == len_q - 1'b1);
  assign busy_o    = busy_q;
  assign err_o     = err_q;
  assign len_o     = LEN_W'(busy_q ? len_q : sent_q);
  assign done_o    = done_q;

  a_r9_push_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && push_i |=> $stable(wr_ptr_q));
  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_sof_o));
  a_r12_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_bad_no_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !busy_q && bad_len |=> !m_valid_o && err_o);
endmodule

// File: rtl/frame_mailbox.sv
module frame_mailbox
  import frame_mailbox_pkg::*;
#(
  parameter int DEPTH_BYTES = 2048,
  parameter int LEN_W       = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic [1:0]  rx_err_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_sof_o,
  output logic        tx_eof_o,
  input  logic        tx_ready_i,
  input  logic        tx_err_i,
  output logic        irq_o
);
  logic             wr, rd, wzero;
  logic             rx_ready, rx_err, rx_crc, tx_busy, tx_err, tx_done;
  logic [LEN_W-1:0] rx_len, tx_len;
  logic [31:0]      rx_word;
  logic [1:0]       irq_en_q;

  assign wr    = reg_req_i & reg_we_i;
  assign rd    = reg_req_i & ~reg_we_i;
  assign wzero = (reg_wdata_i == '0);

  fm_rx_buf #(.DEPTH_BYTES(DEPTH_BYTES), .LEN_W(LEN_W)) i_rx (
    .clk_i, .rst_ni,
    .s_valid_i(rx_valid_i), .s_data_i(rx_data_i), .s_sof_i(rx_sof_i),
    .s_eof_i(rx_eof_i), .s_err_i(rx_err_i),
    .pop_i(rd && reg_addr_i == REG_RX_DATA),
    .ack_i(wr && reg_addr_i == REG_RX_CTRL && wzero),
    .ready_o(rx_ready), .err_o(rx_err), .crc_o(rx_crc), .len_o(rx_len), .word_o(rx_word)
  );

  fm_tx_buf #(.DEPTH_BYTES(DEPTH_BYTES), .LEN_W(LEN_W)) i_tx (
    .clk_i, .rst_ni,
    .push_i(wr && reg_addr_i == REG_TX_DATA), .push_data_i(reg_wdata_i),
    .go_i(wr && reg_addr_i == REG_TX_CTRL && reg_wdata_i[BIT_BUSY]),
    .go_len_i(reg_wdata_i[LEN_W-1:0]),
    .ack_i(wr && reg_addr_i == REG_TX_CTRL && wzero),
    .m_ready_i(tx_ready_i), .m_err_i(tx_err_i),
    .m_valid_o(tx_valid_o), .m_data_o(tx_data_o), .m_sof_o(tx_sof_o), .m_eof_o(tx_eof_o),
    .busy_o(tx_busy), .err_o(tx_err), .len_o(tx_len), .done_o(tx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_en_q <= '0;
    else if (wr && reg_addr_i == REG_IRQ_EN) irq_en_q <= reg_wdata_i[1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_RX_CTRL: begin
        reg_rdata_o[BIT_BUSY]  = rx_ready;
        reg_rdata_o[BIT_ERR]   = rx_err;
        reg_rdata_o[BIT_CRC]   = rx_crc;
        reg_rdata_o[LEN_W-1:0] = rx_len;
      end
      REG_RX_DATA: reg_rdata_o = rx_word;
      REG_TX_CTRL: begin
        reg_rdata_o[BIT_BUSY]  = tx_busy;
        reg_rdata_o[BIT_ERR]   = tx_err;
        reg_rdata_o[LEN_W-1:0] = tx_len;
      end
      REG_IRQ_EN: reg_rdata_o[1:0] = irq_en_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = (rx_ready & irq_en_q[IRQ_RX]) | (tx_done & irq_en_q[IRQ_TX]);

  a_r12_rx_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready && irq_en_q[IRQ_RX] |-> irq_o);
  a_r12_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_q == 2'b00 |-> !irq_o);
endmodule

// File: tb/test_frame_mailbox.sv
module test_frame_mailbox;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [1:0]  rx_err = '0;
  logic        tx_valid, tx_sof, tx_eof, tx_ready = 1'b1, tx_err = 1'b0, irq;
  logic [7:0]  tx_data;

  int n_tests = 0, n_fail = 0;
  int cap_n = 0, exp_n = 0, frame_bad = 0, irq_n = 0;
  bit rnd_rdy = 1'b0;
  logic [7:0] cap [0:4095];

  always #4 clk = ~clk;

  frame_mailbox i_frame_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_err_i(rx_err), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_sof_o(tx_sof), .tx_eof_o(tx_eof), .tx_ready_i(tx_ready),
    .tx_err_i(tx_err), .irq_o(irq)
  );

  // sink model: pick ready for the coming edge, then record the handshake it makes
  always @(negedge clk) begin
    tx_ready = rnd_rdy ? (($urandom % 4) != 0) : 1'b1;
    if (tx_valid && tx_ready) begin
      if (tx_sof != (cap_n == 0) || tx_eof != (cap_n == exp_n - 1)) frame_bad++;
      cap[cap_n] = tx_data;
      cap_n++;
    end
    if (irq) irq_n++;
  end

  function automatic logic [7:0] byte_of(int id, int i);
    return 8'((id * 37 + i * 11 + 5) ^ (i >> 3));
  endfunction

  function automatic logic [31:0] exp_word(int id, int n, int w);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) if (4 * w + k < n) v[8*k +: 8] = byte_of(id, 4 * w + k);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic send_rx(int id, int n, logic [1:0] e);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = byte_of(id, i);
      rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_err = (i == n - 1) ? e : 2'b00;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = '0;
  endtask

  task automatic check_rx(int id, int n, logic [1:0] e, string tag);
    logic [31:0] v, ctl;
    ctl = {1'b1, e[0], e[1], 15'd0, 14'(n)};
    rd(3'd0, v); chk({tag, " R2/R3 rx ctrl"}, v, ctl);
    for (int w = 0; w < (n + 3) / 4; w++) begin
      rd(3'd1, v); chk({tag, " R2 rx word"}, v, exp_word(id, n, w));
    end
    rd(3'd1, v); chk({tag, " R4 read past end"}, v, 32'd0);
    rd(3'd0, v); chk({tag, " R4 ctrl after extra read"}, v, ctl);
  endtask

  task automatic wait_tx_idle(output logic [31:0] v);
    int guard = 0;
    do begin rd(3'd2, v); guard++; end while (v[31] && guard < 20000);
  endtask

  task automatic run_tx(int id, int n, bit inject, bit err_pulse, string tag);
    logic [31:0] v;
    int bad = 0;
    for (int w = 0; w < (n + 3) / 4; w++) wr(3'd3, exp_word(id, n, w));
    cap_n = 0; exp_n = n; frame_bad = 0;
    wr(3'd2, 32'h8000_0000 | 32'(n));
    rd(3'd2, v); chk({tag, " R8 busy while sending"}, v, 32'h8000_0000 | 32'(n));
    if (inject) begin
      wr(3'd3, 32'hDEAD_BEEF);
      wr(3'd2, 32'h8000_0003);
      rd(3'd2, v); chk({tag, " R9 restart ignored"}, v[13:0], 32'(n));
    end
    if (err_pulse) begin tx_err = 1'b1; @(negedge clk); tx_err = 1'b0; end
    wait_tx_idle(v);
    chk({tag, " R8/R10 tx ctrl after done"}, v, {1'b0, err_pulse, 16'd0, 14'(n)});
    chk({tag, " R8 byte count"}, 32'(cap_n), 32'(n));
    for (int i = 0; i < n; i++) if (cap[i] !== byte_of(id, i)) bad++;
    chk({tag, " R8/R9 byte content mismatches"}, 32'(bad), 32'd0);
    chk({tag, " R8 sof/eof marking"}, 32'(frame_bad), 32'd0);
    wr(3'd2, 32'd0);
    rd(3'd2, v); chk({tag, " R10 ack clears tx ctrl"}, v, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lens [4] = '{1, 4, 5, 63};
    int tlens [5] = '{1, 3, 4, 9, 61};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    rd(3'd0, v); chk("R1 rx ctrl reset", v, 0);
    rd(3'd2, v); chk("R1 tx ctrl reset", v, 0);
    rd(3'd4, v); chk("R1 irq en reset", v, 0);
    chk("R1 irq low", 32'(irq), 0);
    chk("R1 tx idle", 32'(tx_valid), 0);
    rd(3'd1, v); chk("R4 read with nothing pending", v, 0);

    // receive: directed lane corners, then random lengths and error tags
    for (int j = 0; j < 4; j++) begin
      send_rx(j, lens[j], 2'b00);
      check_rx(j, lens[j], 2'b00, "dir");
      wr(3'd0, 32'd0);
      rd(3'd0, v); chk("R5 ack clears rx ctrl", v, 0);
    end
    for (int j = 0; j < 8; j++) begin
      int n = 1 + int'($urandom % 300);
      logic [1:0] e = 2'($urandom % 4);
      send_rx(10 + j, n, e);
      if (j == 0) begin
        wr(3'd0, 32'h0000_0001);
        rd(3'd0, v); chk("R5 nonzero write ignored", v[31], 1);
      end
      check_rx(10 + j, n, e, "rnd");
      wr(3'd0, 32'd0);
      rd(3'd0, v); chk("R5 ack after random frame", v, 0);
    end

    // R6: second frame while first pending
    send_rx(30, 17, 2'b00);
    send_rx(31, 40, 2'b11);
    check_rx(30, 17, 2'b00, "R6 pending kept");
    wr(3'd0, 32'd0);
    rd(3'd0, v); chk("R6 dropped frame not presented", v, 0);
    rd(3'd1, v); chk("R6 no data after drop", v, 0);

    // R7: overflow
    send_rx(40, DEPTH + 2, 2'b00);
    rd(3'd0, v); chk("R7 overflow ctrl", v, 32'hC000_0000 | 32'(DEPTH));
    rd(3'd1, v); chk("R7 first word kept", v, exp_word(40, DEPTH, 0));
    wr(3'd0, 32'd0);
    send_rx(41, 6, 2'b00);
    check_rx(41, 6, 2'b00, "R7 after overflow");
    wr(3'd0, 32'd0);

    // transmit
    rnd_rdy = 1'b1;
    for (int j = 0; j < 5; j++) run_tx(50 + j, tlens[j], j == 3, 1'b0, "tx dir");
    for (int j = 0; j < 6; j++) run_tx(60 + j, 1 + int'($urandom % 200), j[0], 1'b0, "tx rnd");
    run_tx(70, 40, 1'b0, 1'b1, "R10 err");

    // R11
    cap_n = 0;
    wr(3'd2, 32'h8000_0000);
    rd(3'd2, v); chk("R11 zero length", v, 32'h4000_0000);
    wr(3'd2, 32'd0);
    wr(3'd2, 32'h8000_0000 | 32'(DEPTH + 1));
    rd(3'd2, v); chk("R11 oversize length", v, 32'h4000_0000);
    chk("R11 no bytes sent", 32'(cap_n), 0);
    wr(3'd2, 32'd0);

    // R12
    rnd_rdy = 1'b0;
    wr(3'd4, 32'd3);
    rd(3'd4, v); chk("R12 enable readback", v, 3);
    send_rx(80, 8, 2'b00);
    chk("R12 rx level irq", 32'(irq), 1);
    wr(3'd0, 32'd0);
    chk("R12 irq drops after ack", 32'(irq), 0);
    irq_n = 0;
    run_tx(81, 12, 1'b0, 1'b0, "R12 tx");
    chk("R12 one pulse per completion", 32'(irq_n), 1);
    wr(3'd4, 32'd0);
    irq_n = 0;
    run_tx(82, 12, 1'b0, 1'b0, "R12 masked");
    wr(3'd4, 32'd2);
    repeat (3) @(negedge clk);
    chk("R12 masked event lost", 32'(irq_n), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule